// File: doc/BRIEF.md
# Descriptor Chain Transmit Engine

This block walks a ring of buffer descriptors in memory and streams the buffer named by each one onto a valid/ready output with byte enables, a frame-start flag and a frame-end flag. Software uses a small write port with three registers. It loads the address of the first descriptor while the channel is halted. It then sets the run bit. Each write to the tail register lets the engine fetch and stream descriptors up to and including the one at the tail address. One output frame may span several descriptors. A flag in the descriptor where the frame opens and a flag in the descriptor where it closes mark the frame's bounds.

Each descriptor is four 32-bit words:
- offset 0: address of the next descriptor
- offset 4: buffer address
- offset 8: control word, with the byte length in bits 22:0, the start flag in bit 27 and the end flag in bit 26
- offset 12: status word, which the engine writes back

All memory traffic goes through one request/response port. A request is held until it is granted. Reads return one data word on a later response cycle, which may carry an error flag. Writes complete on the grant.

The control state machine has eight states:
- `ST_HALT` is the halted state. It leaves for `ST_IDLE` when run is set.
- `ST_IDLE` returns to `ST_HALT` when run is clear, and goes to `ST_DREQ` when a tail write is pending.
- `ST_DREQ` requests one descriptor word and moves to `ST_DRSP` on grant.
- `ST_DRSP` goes back to `ST_DREQ` for the next word. After the control word it goes to `ST_BREQ`, or straight to `ST_STAT` for an empty buffer. On an error response it goes to `ST_HALT`.
- `ST_BREQ` requests one buffer word and moves to `ST_BRSP` on grant.
- `ST_BRSP` moves to `ST_SEND` on a good response and to `ST_HALT` on an error response.
- `ST_SEND` presents the beat. On acceptance it goes to `ST_STAT` after the final beat, to `ST_HALT` if run is clear, and to `ST_BREQ` otherwise.
- `ST_STAT` writes the status word and advances the current pointer. On grant it goes to `ST_IDLE` when the finished descriptor was the tail, to `ST_HALT` if run is clear, and to `ST_DREQ` otherwise.

Top module: `sg_tx_engine`

## Requirements
- R1: After reset the channel is halted (`halted`=1), with no memory request, no stream beat and both interrupt outputs low.
- R2: Writing the control register (select 0) with bit 0 (run) set clears `halted` within three clock cycles. Bit 1 enables the completion interrupt and bit 2 enables the error interrupt.
- R3: No memory request is made while no tail write (select 2) is pending. The first descriptor read after a tail write is at the current pointer. The current pointer (select 1) accepts writes only while halted.
- R4: Each buffer is streamed as ceil(length/4) beats carrying the consecutive 32-bit words that start at the buffer address. `m_tdata` holds steady while a beat waits for `m_tready`.
- R5: `m_tkeep` is 4'b1111 on full beats. On the final beat of a buffer it has one low-order bit set per remaining byte (1 byte gives 0001, 2 give 0011, 3 give 0111).
- R6: `m_tuser` is high only on the first beat of a descriptor whose control bit 27 is set.
- R7: `m_tlast` is high only on the final beat of a descriptor whose control bit 26 is set, so a frame can span descriptors.
- R8: After a descriptor's last beat, the status word at offset 12 is written with the byte count moved, before the next descriptor is read.
- R9: After completing the descriptor whose address equals the tail register, the engine makes no further requests until the tail is written again. It then resumes from that descriptor's next pointer.
- R10: With the completion interrupt enabled, `irq_done` pulses for exactly one cycle after each end-flag descriptor's status write.
- R11: Clearing run lets at most the beat in progress complete, after which `halted` rises and no more beats are sent.
- R12: A read response with `mem_rerr` set pulses `irq_err` (when enabled), clears run and halts the channel, and the status word is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 current pointer, 2 tail pointer |
| cfg_wdata | input | 32 | Register write data |
| halted | output | 1 | Channel halted |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Request is a write (status write-back) |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DW | Stream data |
| m_tkeep | output | DW/8 | Byte enables |
| m_tlast | output | 1 | Final beat of a frame |
| m_tuser | output | 1 | First beat of a frame |

## Verification
The bench builds a ring with buffer lengths of 10, 7, 8 and 5 bytes. This covers every partial-beat byte-enable pattern and a frame that spans two descriptors. A design that mis-sized the last beat or flagged frame ends per descriptor would show wrong `m_tkeep` or extra `m_tlast` beats. The bench stops the tail one descriptor short of the ring's end and then extends it. An engine that ignored the tail would stream the unexpected descriptor early, and one that lost its place would restart at the wrong address. It also clears run in the middle of a long buffer under a stalling sink, and injects a read error on the second beat. These catch a halt that lets the buffer run on, and an error path that still writes status or keeps running.

// File: rtl/sg_tx_pkg.sv
package sg_tx_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_IDLE,
        ST_DREQ,
        ST_DRSP,
        ST_BREQ,
        ST_BRSP,
        ST_SEND,
        ST_STAT
    } eng_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CUR  = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_IOC = 1;
    localparam int CTRL_ERR = 2;

    localparam int LEN_W      = 23;
    localparam int SOF_BIT    = 27;
    localparam int EOF_BIT    = 26;
    localparam int LAST_WORD  = 2;
    localparam int OFF_STATUS = 12;

endpackage

// File: rtl/sg_tx_regs.sv
module sg_tx_regs
    import sg_tx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          halted_i,
    input  logic          adv_i,
    input  logic [AW-1:0] adv_ptr_i,
    input  logic          tail_clr_i,
    input  logic          run_clr_i,
    output logic          run_o,
    output logic          ioc_en_o,
    output logic          err_en_o,
    output logic [AW-1:0] cur_o,
    output logic [AW-1:0] tail_o,
    output logic          tail_pend_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o       <= 1'b0;
            ioc_en_o    <= 1'b0;
            err_en_o    <= 1'b0;
            cur_o       <= '0;
            tail_o      <= '0;
            tail_pend_o <= 1'b0;
        end else begin
            if (run_clr_i)
                run_o <= 1'b0;
            if (cfg_we && cfg_sel == SEL_CTRL) begin
                run_o    <= cfg_wdata[CTRL_RUN];
                ioc_en_o <= cfg_wdata[CTRL_IOC];
                err_en_o <= cfg_wdata[CTRL_ERR];
            end
            if (cfg_we && cfg_sel == SEL_CUR && halted_i)
                cur_o <= cfg_wdata[AW-1:0];
            else if (adv_i)
                cur_o <= adv_ptr_i;
            if (cfg_we && cfg_sel == SEL_TAIL) begin
                tail_o      <= cfg_wdata[AW-1:0];
                tail_pend_o <= 1'b1;
            end else if (tail_clr_i) begin
                tail_pend_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sg_tx_beats.sv
module sg_tx_beats #(
    parameter int AW    = 32,
    parameter int BYTES = 4,
    parameter int LW    = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [AW-1:0]    base_i,
    input  logic [LW-1:0]    len_i,
    input  logic             step_i,
    output logic [AW-1:0]    addr_o,
    output logic [BYTES-1:0] keep_o,
    output logic             last_o
);

    logic [LW-1:0] left_q;

    assign last_o = left_q <= LW'(BYTES);

    for (genvar i = 0; i < BYTES; i++) begin : g_keep
        assign keep_o[i] = left_q > LW'(i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            left_q <= '0;
        end else if (load_i) begin
            addr_o <= base_i;
            left_q <= len_i;
        end else if (step_i) begin
            addr_o <= addr_o + AW'(BYTES);
            left_q <= last_o ? '0 : left_q - LW'(BYTES);
        end
    end

endmodule

// File: rtl/sg_tx_engine.sv
module sg_tx_engine
    import sg_tx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    output logic            halted,
    output logic            irq_done,
    output logic            irq_err,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rerr,
    output logic            m_tvalid,
    input  logic            m_tready,
    output logic [DW-1:0]   m_tdata,
    output logic [DW/8-1:0] m_tkeep,
    output logic            m_tlast,
    output logic            m_tuser
);

    localparam int BYTES = DW / 8;

    eng_state_t state_q, state_d;

    logic [1:0]       idx_q;
    logic [AW-1:0]    next_q, buf_q;
    logic [LEN_W-1:0] len_q;
    logic             eof_q, first_q;
    logic [DW-1:0]    data_q;

    logic             run, ioc_en, err_en, tail_pend;
    logic [AW-1:0]    cur, tail;
    logic [AW-1:0]    beat_addr;
    logic [BYTES-1:0] beat_keep;
    logic             beat_last;

    logic rsp_ok, bad_rsp, desc_done, beat_go, ctl_load, at_tail;

    assign rsp_ok    = mem_rvalid && !mem_rerr;
    assign bad_rsp   = mem_rvalid && mem_rerr &&
                       (state_q == ST_DRSP || state_q == ST_BRSP);
    assign desc_done = state_q == ST_STAT && mem_gnt;
    assign beat_go   = state_q == ST_SEND && m_tready;
    assign ctl_load  = state_q == ST_DRSP && rsp_ok && idx_q == 2'(LAST_WORD);
    assign at_tail   = cur == tail;

    sg_tx_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .halted_i   (halted),
        .adv_i      (desc_done),
        .adv_ptr_i  (next_q),
        .tail_clr_i (desc_done && at_tail),
        .run_clr_i  (bad_rsp),
        .run_o      (run),
        .ioc_en_o   (ioc_en),
        .err_en_o   (err_en),
        .cur_o      (cur),
        .tail_o     (tail),
        .tail_pend_o(tail_pend)
    );

    sg_tx_beats #(.AW(AW), .BYTES(BYTES), .LW(LEN_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(ctl_load),
        .base_i(buf_q),
        .len_i (mem_rdata[LEN_W-1:0]),
        .step_i(beat_go),
        .addr_o(beat_addr),
        .keep_o(beat_keep),
        .last_o(beat_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!run)           state_d = ST_HALT;
                else if (tail_pend) state_d = ST_DREQ;
            end
            ST_DREQ: if (mem_gnt) state_d = ST_DRSP;
            ST_DRSP: begin
                if (bad_rsp)
                    state_d = ST_HALT;
                else if (rsp_ok && idx_q == 2'(LAST_WORD))
                    state_d = (mem_rdata[LEN_W-1:0] == '0) ? ST_STAT : ST_BREQ;
                else if (rsp_ok)
                    state_d = ST_DREQ;
            end
            ST_BREQ: if (mem_gnt) state_d = ST_BRSP;
            ST_BRSP: begin
                if (bad_rsp)     state_d = ST_HALT;
                else if (rsp_ok) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (m_tready) begin
                    if (beat_last) state_d = ST_STAT;
                    else if (!run) state_d = ST_HALT;
                    else           state_d = ST_BREQ;
                end
            end
            ST_STAT: begin
                if (mem_gnt) begin
                    if (at_tail)   state_d = ST_IDLE;
                    else if (!run) state_d = ST_HALT;
                    else           state_d = ST_DREQ;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        halted    = state_q == ST_HALT;
        mem_req   = state_q == ST_DREQ || state_q == ST_BREQ || state_q == ST_STAT;
        mem_we    = state_q == ST_STAT;
        mem_wdata = DW'(len_q);
        m_tvalid  = state_q == ST_SEND;
        m_tdata   = data_q;
        m_tkeep   = m_tvalid ? beat_keep : '0;
        m_tlast   = m_tvalid && eof_q && beat_last;
        m_tuser   = m_tvalid && first_q;
        unique case (state_q)
            ST_DREQ: mem_addr = cur + AW'({idx_q, 2'b00});
            ST_BREQ: mem_addr = beat_addr;
            ST_STAT: mem_addr = cur + AW'(OFF_STATUS);
            default: mem_addr = '0;
        endcase
    end

    // Descriptor, data and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            next_q   <= '0;
            buf_q    <= '0;
            len_q    <= '0;
            eof_q    <= 1'b0;
            first_q  <= 1'b0;
            data_q   <= '0;
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            if (state_q != ST_DREQ && state_q != ST_DRSP)
                idx_q <= '0;
            else if (state_q == ST_DRSP && rsp_ok)
                idx_q <= idx_q + 2'd1;
            if (state_q == ST_DRSP && rsp_ok) begin
                unique case (idx_q)
                    2'd0: next_q <= mem_rdata[AW-1:0];
                    2'd1: buf_q  <= mem_rdata[AW-1:0];
                    default: begin
                        len_q   <= mem_rdata[LEN_W-1:0];
                        eof_q   <= mem_rdata[EOF_BIT];
                        first_q <= mem_rdata[SOF_BIT];
                    end
                endcase
            end
            if (state_q == ST_BRSP && rsp_ok)
                data_q <= mem_rdata;
            if (beat_go)
                first_q <= 1'b0;
            irq_done <= desc_done && eof_q && ioc_en;
            irq_err  <= bad_rsp && err_en;
        end
    end

endmodule

// File: rtl/sg_tx_engine_chk.sv
module sg_tx_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halted,
    input logic            irq_done,
    input logic            irq_err,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_gnt,
    input logic            m_tvalid,
    input logic            m_tready,
    input logic [DW-1:0]   m_tdata,
    input logic [DW/8-1:0] m_tkeep,
    input logic            m_tlast
);

    // R4
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R12
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> halted);

    // R5
    keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tkeep[0]);

endmodule

bind sg_tx_engine sg_tx_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted  (halted),
    .irq_done(irq_done),
    .irq_err (irq_err),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .mem_gnt (mem_gnt),
    .m_tvalid(m_tvalid),
    .m_tready(m_tready),
    .m_tdata (m_tdata),
    .m_tkeep (m_tkeep),
    .m_tlast (m_tlast)
);

// File: tb/sg_tx_engine_bench.sv
module sg_tx_engine_bench;

    localparam int WD_LIMIT = 100000;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  k;
        logic        l;
        logic        u;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        halted, irq_done, irq_err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt, mem_rvalid, mem_rerr;
    logic [31:0] mem_rdata;
    logic        m_tvalid, m_tready, m_tlast, m_tuser;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;

    always #5 clk = ~clk;

    sg_tx_engine u_sg_tx_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .halted(halted), .irq_done(irq_done), .irq_err(irq_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    // Memory image (written by the stimulus only) and status store (written by the model only)
    logic [31:0] mem      [0:255];
    logic [31:0] stat_mem [0:255];
    logic        stat_wr  [0:255];
    logic [31:0] addr_log [0:511];
    int          req_cnt;
    logic [31:0] err_addr;
    logic        slow_ready;
    logic [7:0]  cyc;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc        <= '0;
            mem_gnt    <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
            mem_rdata  <= '0;
            m_tready   <= 1'b0;
            for (int i = 0; i < 256; i++) stat_wr[i] <= 1'b0;
        end else begin
            cyc        <= cyc + 8'd1;
            mem_gnt    <= cyc[1:0] != 2'b11;
            m_tready   <= slow_ready ? (cyc[0] ^ cyc[2]) : 1'b1;
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    stat_mem[mem_addr[9:2]] <= mem_wdata;
                    stat_wr[mem_addr[9:2]]  <= 1'b1;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr[9:2]];
                    mem_rerr   <= mem_addr == err_addr;
                end
            end
        end
    end

    // Request log, interrupt counters
    int done_cnt, err_cnt;
    always @(negedge clk) begin
        if (!rst_n) begin
            req_cnt  <= 0;
            done_cnt <= 0;
            err_cnt  <= 0;
        end else begin
            if (mem_req && mem_gnt) begin
                if (req_cnt < 512) addr_log[req_cnt] <= mem_addr;
                req_cnt <= req_cnt + 1;
            end
            if (irq_done) done_cnt <= done_cnt + 1;
            if (irq_err)  err_cnt  <= err_cnt + 1;
        end
    end

    // Scoreboard monitor
    beat_t exp_q[$];
    int mon_cmp, mon_bad, mon_beats;
    initial begin
        mon_cmp = 0; mon_bad = 0; mon_beats = 0;
    end
    always @(negedge clk) begin
        if (rst_n && m_tvalid && m_tready) begin
            beat_t e;
            mon_beats++;
            mon_cmp++;
            if (exp_q.size() == 0) begin
                mon_bad++;
                $display("FAIL R9: unexpected beat data=%h, expected no beat", m_tdata);
            end else begin
                e = exp_q.pop_front();
                if (m_tdata !== e.d) begin
                    mon_bad++;
                    $display("FAIL R4: data %h expected %h", m_tdata, e.d);
                end
                mon_cmp++;
                if (m_tkeep !== e.k) begin
                    mon_bad++;
                    $display("FAIL R5: keep %b expected %b", m_tkeep, e.k);
                end
                mon_cmp++;
                if (m_tuser !== e.u) begin
                    mon_bad++;
                    $display("FAIL R6: user %b expected %b", m_tuser, e.u);
                end
                mon_cmp++;
                if (m_tlast !== e.l) begin
                    mon_bad++;
                    $display("FAIL R7: last %b expected %b", m_tlast, e.l);
                end
            end
        end
    end

    int n_cmp, n_bad;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dword(input logic [31:0] a);
        return 32'hC0DE_0000 ^ a;
    endfunction

    // Driver: lays a descriptor and its buffer into memory, pushes expected beats
    task automatic add_desc(input int at, input int nxt, input int bufa, input int len,
                            input bit sof, input bit eof, input bit push);
        int nb;
        mem[at/4]     = nxt;
        mem[at/4 + 1] = bufa;
        mem[at/4 + 2] = len | (int'(sof) << 27) | (int'(eof) << 26);
        nb = (len + 3) / 4;
        for (int w = 0; w < nb; w++) begin
            beat_t b;
            int rem;
            mem[bufa/4 + w] = dword(bufa + 4*w);
            rem = len - 4*w;
            b.d = dword(bufa + 4*w);
            b.k = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            b.l = eof && (w == nb - 1);
            b.u = sof && (w == 0);
            if (push) exp_q.push_back(b);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic run_tests();
        int snap, b0, b1, e0;
        // R2: run clears halted
        cfg_write(2'd1, 32'h0);
        cfg_write(2'd0, 32'h7);
        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R2", "halted after run", 32'(halted), 0);

        // R3: current pointer ignored while running; no fetch before tail write
        cfg_write(2'd1, 32'h40);
        snap = req_cnt;
        repeat (20) @(negedge clk);
        check(req_cnt == snap, "R3", "requests before tail write", req_cnt, snap);

        // Frame across D0/D1, single-descriptor frame D2, stop at tail D2
        cfg_write(2'd2, 32'h20);
        wait_drain();
        check(addr_log[snap] == 32'h0, "R3", "first descriptor read address", addr_log[snap], 0);
        check(stat_wr[3] && stat_mem[3] == 10, "R8", "status D0", stat_mem[3], 10);
        check(stat_wr[7] && stat_mem[7] == 7, "R8", "status D1", stat_mem[7], 7);
        check(stat_wr[11] && stat_mem[11] == 8, "R8", "status D2", stat_mem[11], 8);
        check(!stat_wr[15], "R9", "D3 status untouched past tail", 32'(stat_wr[15]), 0);
        check(done_cnt == 2, "R10", "completion pulses", done_cnt, 2);
        snap = req_cnt;
        repeat (30) @(negedge clk);
        check(req_cnt == snap && !halted, "R9", "idle after tail", req_cnt, snap);

        // R9 resume from D2's next pointer, with a stalling sink
        add_desc(32'h30, 32'h00, 32'h2C0, 5, 1, 1, 1);
        slow_ready = 1'b1;
        cfg_write(2'd2, 32'h30);
        wait_drain();
        check(addr_log[snap] == 32'h30, "R9", "resume descriptor address", addr_log[snap], 32'h30);
        check(stat_wr[15] && stat_mem[15] == 5, "R8", "status D3", stat_mem[15], 5);
        check(done_cnt == 3, "R10", "completion pulses after resume", done_cnt, 3);

        // R11: clear run in the middle of a long buffer
        add_desc(32'h00, 32'h10, 32'h200, 40, 1, 1, 1);
        b0 = mon_beats;
        cfg_write(2'd2, 32'h00);
        while (mon_beats < b0 + 3) @(negedge clk);
        cfg_write(2'd0, 32'h6);
        b1 = mon_beats;
        repeat (40) @(negedge clk);
        check(mon_beats - b1 <= 1, "R11", "beats after run cleared", mon_beats - b1, 1);
        check(halted == 1'b1, "R11", "halted after run cleared", 32'(halted), 1);
        exp_q.delete();
        slow_ready = 1'b0;

        // R12: read error on the second beat
        add_desc(32'h40, 32'h50, 32'h300, 8, 1, 1, 0);
        begin
            beat_t b;
            b.d = dword(32'h300); b.k = 4'hF; b.l = 1'b0; b.u = 1'b1;
            exp_q.push_back(b);
        end
        err_addr = 32'h304;
        cfg_write(2'd1, 32'h40);
        e0 = err_cnt;
        cfg_write(2'd0, 32'h7);
        cfg_write(2'd2, 32'h40);
        wait_drain();
        check(err_cnt == e0 + 1, "R12", "error pulses", err_cnt, e0 + 1);
        check(halted == 1'b1, "R12", "halted after error", 32'(halted), 1);
        check(!stat_wr[19], "R12", "no status after error", 32'(stat_wr[19]), 0);
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R12", "run stays cleared", 32'(halted), 1);
    endtask

    initial begin
        n_cmp = 0; n_bad = 0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        slow_ready = 1'b0; err_addr = 32'hFFFF_FFF0;
        add_desc(32'h00, 32'h10, 32'h200, 10, 1, 0, 1);
        add_desc(32'h10, 32'h20, 32'h240, 7, 0, 1, 1);
        add_desc(32'h20, 32'h30, 32'h280, 8, 1, 1, 1);
        add_desc(32'h30, 32'h00, 32'h2C0, 5, 1, 1, 0);
        repeat (4) @(negedge clk);
        check(halted == 1'b1, "R1", "halted in reset", 32'(halted), 1);
        check(!mem_req && !m_tvalid, "R1", "req/valid in reset", {mem_req, m_tvalid}, 0);
        check(!irq_done && !irq_err, "R1", "irqs in reset", {irq_done, irq_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (WD_LIMIT) @(posedge clk);
                check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp + mon_cmp, n_bad + mon_bad);
        $finish;
    end

endmodule